// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits next to the decode stage of a five-stage in-order pipeline. It spots one case that forwarding cannot fix. That case is a memory load in the execute stage whose destination register is a source of the instruction now in decode. The loaded value arrives a cycle too late to be forwarded to that consumer, so the block holds the front of the pipeline for exactly one cycle.

During a stall the block freezes the program counter and the fetch/decode latch. It also tells the pipeline to load an all-zero control word into the decode/execute latch. The bubble then moves forward, and the consumer is decoded again one cycle later. By then the load is one stage further on and forwarding can supply the data. All other read-after-write distances are left to the forwarding network, and their cost here is zero cycles.

The detection itself is combinational, so the stall acts in the same cycle the hazard appears. One flop remembers whether the previous cycle was a stall. A hazard pattern seen in the cycle right after a stall is not allowed to stall again. This keeps the penalty at one cycle per load.

Top module: `load_use_stall`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a`, and the previous cycle was not a stall, the block stalls in that same cycle. A stall means `pc_wr_en`=0, `id_latch_wr_en`=0 and `ex_ctrl_clear`=1.
- R2: When `ex_is_load` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_b`, and the previous cycle was not a stall, the block stalls in that same cycle.
- R3: While `ex_is_load` is 0, the block never stalls, whatever the register indices are.
- R4: A load whose destination index is 0 never causes a stall, even when both source indices are 0.
- R5: A load whose destination matches neither source index does not stall. Outside a stall, `pc_wr_en`=1, `id_latch_wr_en`=1 and `ex_ctrl_clear`=0.
- R6: In every cycle, `pc_wr_en` equals `id_latch_wr_en`, and `ex_ctrl_clear` is their inverse.
- R7: A stall lasts exactly one cycle. In the cycle right after a stall, the outputs return to the no-stall values even if the hazard pattern is still present. A pattern held without change therefore stalls on alternate cycles.
- R8: Reset clears the memory of a previous stall. A hazard in the first cycle after reset stalls.
- R9: In a sequence load, dependent load, dependent consumer, each dependency stalls once. The bubble between them does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_is_load | input | 1 | Decode/execute latch: the instruction reads data memory |
| ex_dst | input | RW | Decode/execute latch: destination index of the load (its rt field) |
| id_src_a | input | RW | Fetch/decode latch: first source index (rs) |
| id_src_b | input | RW | Fetch/decode latch: second source index (rt) |
| pc_wr_en | output | 1 | Program counter may update |
| id_latch_wr_en | output | 1 | Fetch/decode latch may update |
| ex_ctrl_clear | output | 1 | Load zeroed control bits into the decode/execute latch |

## Verification
Two functions can fall in the same cycle: fresh hazard detection, and the suppression of a second stall right after the first. Holding one hazard pattern over several consecutive cycles makes the two collide. The expected result is a stall, then a release, then a stall again, with the bench's own one-cycle history deciding each step. A full sweep of all index triples is interleaved with idle cycles, so that every pattern is judged with a clean history. A short load, load, consumer program then checks the back-to-back case.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_is_load,
  input  logic [RW-1:0] ex_dst,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  output logic          pc_wr_en,
  output logic          id_latch_wr_en,
  output logic          ex_ctrl_clear
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic dst_live, hit_a, hit_b, hazard, stall, stalled_q;

  assign dst_live = ex_is_load && (ex_dst != ZERO_REG);
  assign hit_a    = (ex_dst == id_src_a);
  assign hit_b    = (ex_dst == id_src_b);
  assign hazard   = dst_live && (hit_a || hit_b);
  assign stall    = hazard && !stalled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall;
  end

  assign pc_wr_en       = !stall;
  assign id_latch_wr_en = !stall;
  assign ex_ctrl_clear  = stall;
endmodule

// File: rtl/load_use_stall_chk.sv
module load_use_stall_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_is_load,
  input logic [RW-1:0] ex_dst,
  input logic [RW-1:0] id_src_a,
  input logic [RW-1:0] id_src_b,
  input logic          pc_wr_en,
  input logic          id_latch_wr_en,
  input logic          ex_ctrl_clear
);
  logic prev_clear;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_clear <= 1'b0;
    else        prev_clear <= ex_ctrl_clear;
  end

  // R6
  outputs_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_en == id_latch_wr_en) && (ex_ctrl_clear == !pc_wr_en));

  // R3
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !ex_ctrl_clear);

  // R4
  zero_dst_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !ex_ctrl_clear);

  // R7
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ctrl_clear |=> !ex_ctrl_clear);

  // R1
  src_a_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst != '0 && ex_dst == id_src_a && !prev_clear) |-> ex_ctrl_clear);

  // R2
  src_b_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst != '0 && ex_dst == id_src_b && !prev_clear) |-> ex_ctrl_clear);
endmodule

bind load_use_stall load_use_stall_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
  .id_src_a(id_src_a), .id_src_b(id_src_b), .pc_wr_en(pc_wr_en),
  .id_latch_wr_en(id_latch_wr_en), .ex_ctrl_clear(ex_ctrl_clear)
);

// File: tb/load_use_stall_tb.sv
module load_use_stall_tb;
  localparam int RW = 5;
  localparam int NREG = 1 << RW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ex_is_load = 1'b0;
  logic [RW-1:0] ex_dst = '0, id_src_a = '0, id_src_b = '0;
  logic pc_wr_en, id_latch_wr_en, ex_ctrl_clear;
  int checks = 0, failures = 0;
  bit prev_stall = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  load_use_stall #(.RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .pc_wr_en(pc_wr_en),
    .id_latch_wr_en(id_latch_wr_en), .ex_ctrl_clear(ex_ctrl_clear)
  );

  task automatic check_out(input bit exp_stall, input string req);
    logic [2:0] act, exp;
    act = {pc_wr_en, id_latch_wr_en, ex_ctrl_clear};
    exp = exp_stall ? 3'b001 : 3'b110;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%b exp=%b load=%0b dst=%0d a=%0d b=%0d",
               req, act, exp, ex_is_load, ex_dst, id_src_a, id_src_b);
    end
  endtask

  task automatic step(input bit ld, input int d, input int a, input int b, input string req);
    bit e;
    @(negedge clk);
    ex_is_load = ld; ex_dst = RW'(d); id_src_a = RW'(a); id_src_b = RW'(b);
    #5;
    e = ld && d != 0 && (d == a || d == b) && !prev_stall;
    check_out(e, req);
    prev_stall = e;
  endtask

  initial begin
    #400000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3;
    check_out(1'b0, "reset R5");
    #60;
    rst_n = 1'b1;
    // R8: hazard in the first cycle after reset
    step(1, 7, 7, 0, "R8");
    step(0, 0, 0, 0, "R3");
    // R1, R2, R4, R5: full sweep of loads, idle cycle between
    for (int d = 0; d < NREG; d++)
      for (int a = 0; a < NREG; a++)
        for (int b = 0; b < NREG; b++) begin
          step(1, d, a, b, d == 0 ? "R4" : (d == a ? "R1" : (d == b ? "R2" : "R5")));
          step(0, d, a, b, "R3");
        end
    // R7: held hazard alternates
    step(1, 9, 9, 9, "R7");
    step(1, 9, 9, 9, "R7");
    step(1, 9, 9, 9, "R7");
    step(1, 9, 3, 9, "R7");
    step(0, 0, 0, 0, "R3");
    // R9: load r2; load r3 <- (r2); bubble; add uses r3; bubble
    step(1, 2, 1, 2, "R9");
    step(0, 0, 2, 3, "R9");
    step(1, 3, 2, 3, "R9");
    step(0, 0, 3, 5, "R9");
    step(0, 0, 6, 7, "R9");
    // R6 by construction of check_out on each step above
    step(1, 31, 0, 31, "R6");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule